// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned or two's complement operands and a carry-in. It produces a 16-bit sum and a carry-out, with no clock and no storage. It is split into four 4-bit slices. Each slice forms a generate term (the bits are both one) and a propagate term (either bit is one) for every bit position. It expands these into the carries inside the slice, then condenses them into one slice-generate and one slice-propagate signal.

A second lookahead stage takes the four slice-generate/propagate pairs and the carry-in. It forms the carry into every slice at once, as a flat sum of products. Carries therefore never ripple from slice to slice. The carry-out of the whole adder is the carry leaving the most significant slice.

The slice width and the slice count are parameters. The defaults give 16 bits.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i` for all operand and carry-in values.
- R2: `cout_o` equals bit 16 of the 17-bit value `a_i + b_i + cin_i`.
- R3: A slice in which every bit position has both operand bits at one emits a carry into the next slice, whatever the lower bits and the carry-in are.
- R4: A carry entering the least significant bit passes through every position whose operand bits are exactly one 1 and one 0. With `a_i = 16'hFFFF`, `b_i = 0` and `cin_i = 1`, the result is `sum_o = 0` and `cout_o = 1`.
- R5: The carry into each slice k (bit position 4k, observable as `sum_o[4k] ^ a_i[4k] ^ b_i[4k]`) equals the value a bit-serial ripple addition would produce at that position.
- R6: `cout_o` is the carry leaving the most significant slice. It equals that slice's own generate term OR its propagate term AND the carry entering it.
- R7: The outputs are purely combinational. They are valid in the same cycle the inputs are applied, with no register stage.
- R8: With both operands zero and `cin_i = 0`, `sum_o = 0` and `cout_o = 0`. With both operands zero and `cin_i = 1`, `sum_o = 1` and `cout_o = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench applies each operand set just after a rising clock edge. It samples the sum, the carry-out and the slice-boundary carries recovered from the sum at the following falling edge, half a period later, when the logic has settled. Expected values come from a bench-side 17-bit addition and from a bit-serial ripple model. These are applied to a fixed-seed random mix and to directed slice-generate, full-propagate and zero cases.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned CLA_GROUP_W    = 4;
    localparam int unsigned CLA_NUM_GROUPS = 4;
    localparam int unsigned CLA_WIDTH      = CLA_GROUP_W * CLA_NUM_GROUPS;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
    parameter int unsigned W = cla_pkg::CLA_GROUP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_in,
    output logic [W-1:0] sum_o,
    output logic         gen_o,
    output logic         prop_o,
    output logic         carry_o
);
    typedef struct packed {
        logic [W-1:0] g;
        logic [W-1:0] p;
        logic         grp_gen;
        logic         grp_prop;
    } gp_state_t;

    typedef struct packed {
        logic [W:0]   c;
        logic [W-1:0] s;
    } carry_state_t;

    gp_state_t    gp_d;
    carry_state_t cs_d;

    // Bit and slice generate/propagate: operands only.
    always_comb begin
        logic prod;
        gp_d.g        = a_i & b_i;
        gp_d.p        = a_i | b_i;
        gp_d.grp_gen  = 1'b0;
        gp_d.grp_prop = 1'b1;
        for (int j = 0; j < int'(W); j++) begin
            prod = gp_d.g[j];
            for (int k = j + 1; k < int'(W); k++) begin
                prod = prod & gp_d.p[k];
            end
            gp_d.grp_gen  = gp_d.grp_gen | prod;
            gp_d.grp_prop = gp_d.grp_prop & gp_d.p[j];
        end
    end

    // Internal carries, each fully expanded in g, p and c_in.
    always_comb begin
        logic prod;
        logic acc;
        cs_d.c[0] = c_in;
        for (int i = 0; i < int'(W); i++) begin
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod = gp_d.g[j];
                for (int k = j + 1; k <= i; k++) begin
                    prod = prod & gp_d.p[k];
                end
                acc = acc | prod;
            end
            prod = c_in;
            for (int k = 0; k <= i; k++) begin
                prod = prod & gp_d.p[k];
            end
            cs_d.c[i+1] = acc | prod;
        end
        cs_d.s = a_i ^ b_i ^ cs_d.c[W-1:0];
        // R3: expanded bit-level carry out agrees with slice generate/propagate
        assert_group_carry_R3: assert (cs_d.c[W] == (gp_d.grp_gen | (gp_d.grp_prop & c_in)))
            else $error("slice carry disagrees with slice generate/propagate");
    end

    assign sum_o   = cs_d.s;
    assign gen_o   = gp_d.grp_gen;
    assign prop_o  = gp_d.grp_prop;
    assign carry_o = cs_d.c[W];
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = cla_pkg::CLA_NUM_GROUPS
) (
    input  cla_pkg::gp_pair_t [N-1:0] gp_i,
    input  logic                      c0_i,
    output logic [N:0]                carry_o
);
    typedef struct packed {
        logic [N:0] c;
        logic [N:0] rip;
    } la_state_t;

    la_state_t la_d;

    always_comb begin
        logic prod;
        logic acc;
        la_d.c[0]   = c0_i;
        la_d.rip[0] = c0_i;
        for (int i = 0; i < int'(N); i++) begin
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod = gp_i[j].gen;
                for (int k = j + 1; k <= i; k++) begin
                    prod = prod & gp_i[k].prop;
                end
                acc = acc | prod;
            end
            prod = c0_i;
            for (int k = 0; k <= i; k++) begin
                prod = prod & gp_i[k].prop;
            end
            la_d.c[i+1]   = acc | prod;
            la_d.rip[i+1] = gp_i[i].gen | (gp_i[i].prop & la_d.rip[i]);
        end
        // R5: flat lookahead carries agree with a slice-to-slice ripple
        assert_lookahead_ripple_R5: assert (la_d.c == la_d.rip)
            else $error("lookahead carries differ from ripple form");
    end

    assign carry_o = la_d.c;
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int unsigned GROUP_W    = cla_pkg::CLA_GROUP_W,
    parameter int unsigned NUM_GROUPS = cla_pkg::CLA_NUM_GROUPS,
    localparam int unsigned WIDTH     = GROUP_W * NUM_GROUPS
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    cla_pkg::gp_pair_t [NUM_GROUPS-1:0] grp_gp;
    logic [NUM_GROUPS:0]                grp_carry;
    logic [NUM_GROUPS-1:0]              grp_cout;

    for (genvar gi = 0; gi < int'(NUM_GROUPS); gi++) begin : g_slice
        logic g_gen;
        logic g_prop;
        cla_group #(.W(GROUP_W)) u_group (
            .a_i    (a_i[gi*GROUP_W +: GROUP_W]),
            .b_i    (b_i[gi*GROUP_W +: GROUP_W]),
            .c_in   (grp_carry[gi]),
            .sum_o  (sum_o[gi*GROUP_W +: GROUP_W]),
            .gen_o  (g_gen),
            .prop_o (g_prop),
            .carry_o(grp_cout[gi])
        );
        assign grp_gp[gi].gen  = g_gen;
        assign grp_gp[gi].prop = g_prop;
    end

    cla_lookahead #(.N(NUM_GROUPS)) u_lookahead (
        .gp_i   (grp_gp),
        .c0_i   (cin_i),
        .carry_o(grp_carry)
    );

    assign cout_o = grp_carry[NUM_GROUPS];

    always_comb begin
        logic [WIDTH:0] ref_total;
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        // R1, R2: sum and carry-out are the exact arithmetic result
        assert_sum_exact_R1: assert ({cout_o, sum_o} == ref_total)
            else $error("adder output differs from a + b + cin");
        // R6: top-level carry-out equals the top slice's own carry
        assert_cout_top_R6: assert (cout_o == grp_cout[NUM_GROUPS-1])
            else $error("carry-out differs from top slice carry");
    end
endmodule

// File: tb/cla_adder16_test.sv
module cla_adder16_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, s;
    logic         ci, co;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder16 uut (.a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));

    function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [W:0] ripple(logic [W-1:0] x, logic [W-1:0] y, logic c);
        logic [W:0] r;
        r[0] = c;
        for (int i = 0; i < W; i++) r[i+1] = (x[i] & y[i]) | ((x[i] ^ y[i]) & r[i]);
        return r;
    endfunction

    task automatic cmp(string tag, logic [W:0] act, logic [W:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic c);
        @(posedge clk);
        #1;
        a = x; b = y; ci = c;
        @(negedge clk);
    endtask

    // R1, R2, R5 checks at the sampling point of the current vector
    task automatic check_vec();
        logic [W:0] e;
        logic [W:0] r;
        e = ref_add(a, b, ci);
        r = ripple(a, b, ci);
        cmp("R1 sum", {1'b0, s}, {1'b0, e[W-1:0]});
        cmp("R2 cout", {{W{1'b0}}, co}, {{W{1'b0}}, e[W]});
        for (int k = 0; k < 4; k++)
            cmp("R5 slice carry", {{W{1'b0}}, s[4*k] ^ a[4*k] ^ b[4*k]}, {{W{1'b0}}, r[4*k]});
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        void'($urandom(32'd20240611));
        // R8 zero operands
        apply(16'h0000, 16'h0000, 1'b0);
        cmp("R8 zero", {co, s}, 17'h0);
        apply(16'h0000, 16'h0000, 1'b1);
        cmp("R8 zero+cin", {co, s}, 17'h00001);
        // R4 full propagate chain
        apply(16'hFFFF, 16'h0000, 1'b1);
        cmp("R4 propagate", {co, s}, 17'h10000);
        apply(16'hA5A5, 16'h5A5A, 1'b1);
        cmp("R4 alt propagate", {co, s}, 17'h10000);
        // R3 slice generate regardless of lower bits and cin
        for (int k = 0; k < 3; k++) begin
            for (int c = 0; c < 2; c++) begin
                logic [W-1:0] x;
                logic [W-1:0] y;
                x = (16'hF << (4*k)) | ($urandom() & ((16'h1 << (4*k)) - 16'h1));
                y = (16'hF << (4*k));
                apply(x, y, c[0]);
                cmp("R3 generate", {{W{1'b0}}, s[4*k+4] ^ a[4*k+4] ^ b[4*k+4]}, {{W{1'b0}}, 1'b1});
                check_vec();
            end
        end
        // R6 top slice generate drives cout
        apply(16'hF000, 16'hF000, 1'b0);
        cmp("R6 top generate", {co, s}, 17'h1E000);
        apply(16'h0FFF, 16'hF001, 1'b0);
        cmp("R6 lookahead into top", {co, s}, 17'h10000);
        // R7 same-cycle result under random stimulus
        for (int i = 0; i < 400; i++) begin
            apply(16'($urandom()), 16'($urandom()), 1'($urandom()));
            check_vec();
            if (i == 0) cmp("R7 same cycle", {co, s}, ref_add(a, b, ci));
        end
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        check_vec();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule